// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Run-Time Ratio Selection

This block turns a one-bit oversampled stream from a delta-sigma modulator into signed multi-bit words. Each accepted input bit counts as +1 when high and −1 when low. Three cascaded accumulators run at the input sample rate. Every OSR accepted samples the third accumulator is decimated, and three first-difference stages then run at the output rate. Together they realise the response ((1 − z^−OSR)/(1 − z^−1))^3. Output words therefore appear at the sample rate divided by OSR, and the first notch of the response sits at that rate. The block is meant as a first, low-ratio stage ahead of a sharper filter.

The ratio is chosen at run time from the powers of two between 16 and 256. Whatever the ratio, each word is scaled and clamped to a fixed 16-bit two's-complement range, so a downstream stage sees the same full scale at every setting. Changing the ratio empties the filter. A settled flag stays low until the filter has produced as many words as its order.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is held and directly after it, `word_out` is 0, and `word_valid` and `settled` are low.
- R2: The internal arithmetic wraps modulo 2^26 (2 + 3·8 bits). Per accepted sample the three accumulators update as a1 += x, a2 += old a1 and a3 += old a2. At decimation the raw result is the third of three chained first differences of the new a3 value, each taken against its value at the previous decimation.
- R3: `word_valid` pulses for exactly one cycle, in the cycle after the edge that takes in the OSR-th accepted sample of a frame. Cycles with `bit_valid` low change no state.
- R4: `osr_code` k selects OSR = 2^(4+k) for k = 0 to 4 (16, 32, 64, 128, 256). Codes 5, 6 and 7 act exactly as code 4, so moving between any of codes 4 to 7 does not disturb the filter.
- R5: The word is the raw result arithmetically shifted right by 3·log2(OSR) − 15, or shifted left by 3 at OSR 16, then clamped to [−32768, 32767].
- R6: A change in the effective ratio clears all filter state in the same edge and discards any sample offered in that cycle. In the following cycle `word_valid` and `settled` are low.
- R7: `settled` rises in the same cycle as the third `word_valid` pulse after reset or after a ratio change, and stays high until the next ratio change.
- R8: Once the filter has settled, a constant 1 input gives 32767, a constant 0 input gives −32768, and a strictly alternating input gives exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Modulator bit |
| bit_valid | input | 1 | Sample strobe for `bit_in` |
| osr_code | input | 3 | Ratio selection, see R4 |
| word_out | output | 16 | Scaled signed output word |
| word_valid | output | 1 | One-cycle strobe for `word_out` |
| settled | output | 1 | Filter has passed its settling period |

## Verification
The bench uses the default parameters, a minimum exponent of 4 and a maximum of 8. This covers all five ratios, the left-shift scaling path at OSR 16, the widest accumulators at OSR 256, and the aliasing of codes above 4. Constant inputs drive the raw result to exactly ±OSR³. This exercises clamping at both ends of the range and the one value that a register one bit narrower could not hold. Ratio changes in the middle of a frame, together with sparse strobes, test the flush and settle sequence against the decimation counter.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int LOG_W = 4;

    // ratio code to log2(OSR), clamped at the largest supported ratio
    function automatic logic [LOG_W-1:0] code_to_log2(input logic [2:0] code,
                                                      input int lmin,
                                                      input int lmax);
        int t;
        t = lmin + int'(code);
        if (t > lmax) t = lmax;
        return LOG_W'(t);
    endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             smp_ok,
    input  logic             smp_bit,
    output logic [ACC_W-1:0] acc3_next
);
    localparam int STAGES = 3;

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else if (smp_ok) begin
            s_d.acc[0] = s_q.acc[0] + (smp_bit ? ACC_W'(1) : {ACC_W{1'b1}});
            for (int k = 1; k < STAGES; k++) begin
                s_d.acc[k] = s_q.acc[k] + s_q.acc[k-1];
            end
        end
    end

    assign acc3_next = s_d.acc[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: no accepted sample and no flush leaves the accumulators untouched
    assert_integ_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_ok && !flush) |=> $stable(s_q));

endmodule

// File: rtl/sinc3_count.sv
module sinc3_count #(
    parameter int LMAX  = 8,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             smp_ok,
    input  logic [LOG_W-1:0] log2_osr,
    output logic             fire
);
    typedef struct packed {
        logic [LMAX-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [LMAX-1:0] limit;

    always_comb begin
        limit = LMAX'((32'd1 << log2_osr) - 32'd1);
        fire  = smp_ok && !flush && (s_q.cnt == limit);
        s_d   = s_q;
        if (flush)       s_d.cnt = '0;
        else if (fire)   s_d.cnt = '0;
        else if (smp_ok) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: the sample position never runs past the current ratio
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= limit);

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ACC_W = 26,
    parameter int OUT_W = 16,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fire,
    input  logic [ACC_W-1:0] din,
    input  logic [LOG_W-1:0] log2_osr,
    output logic [OUT_W-1:0] word,
    output logic             word_valid,
    output logic             settled
);
    localparam int STAGES = 3;
    localparam int WW     = ACC_W + OUT_W;
    localparam logic signed [WW-1:0] MAXV = WW'((64'sd1 <<< (OUT_W-1)) - 1);
    localparam logic signed [WW-1:0] MINV = -MAXV - 1;

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] dly;
        logic [OUT_W-1:0]             word;
        logic                         valid;
        logic [1:0]                   nwords;
        logic                         settled;
    } comb_t;

    comb_t s_d, s_q;
    logic [ACC_W-1:0]     raw;
    logic signed [WW-1:0] ext, shifted;
    int                   sh;

    always_comb begin
        logic [ACC_W-1:0] stage;
        s_d       = s_q;
        s_d.valid = 1'b0;
        stage     = din;
        for (int k = 0; k < STAGES; k++) begin
            s_d.dly[k] = stage;
            stage      = stage - s_q.dly[k];
        end
        raw = stage;

        ext = {{OUT_W{raw[ACC_W-1]}}, raw};
        sh  = STAGES * int'(log2_osr) - (OUT_W - 1);
        if (sh >= 0) shifted = ext >>> sh;
        else         shifted = ext <<< (-sh);

        if (flush) begin
            s_d = '0;
        end else if (fire) begin
            if (shifted > MAXV)      s_d.word = MAXV[OUT_W-1:0];
            else if (shifted < MINV) s_d.word = MINV[OUT_W-1:0];
            else                     s_d.word = shifted[OUT_W-1:0];
            s_d.valid   = 1'b1;
            s_d.nwords  = (s_q.nwords == 2'd3) ? 2'd3 : s_q.nwords + 2'd1;
            s_d.settled = (s_d.nwords == 2'd3);
        end else begin
            s_d.dly = s_q.dly;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word       = s_q.word;
    assign word_valid = s_q.valid;
    assign settled    = s_q.settled;

    // R6: a flush leaves neither a pending word nor the settled flag
    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!s_q.valid && !s_q.settled));

    // R7: settling is only ever announced together with a word
    assert_settle_on_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.settled) |-> s_q.valid);

    // R3: a word strobe never lasts two cycles
    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid);

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
    parameter int LMIN  = 4,
    parameter int LMAX  = 8,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic [2:0]       osr_code,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid,
    output logic             settled
);
    import sinc3_pkg::*;

    localparam int ACC_W = 2 + 3 * LMAX;

    typedef struct packed {
        logic [LOG_W-1:0] log2_osr;
    } top_t;

    top_t s_d, s_q;
    logic flush, smp_ok, fire;
    logic [ACC_W-1:0] acc3_next;

    always_comb begin
        s_d.log2_osr = code_to_log2(osr_code, LMIN, LMAX);
        flush        = (s_d.log2_osr != s_q.log2_osr);
        smp_ok       = bit_valid && !flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.log2_osr <= LOG_W'(LMIN);
        else        s_q <= s_d;
    end

    sinc3_integ #(.ACC_W(ACC_W)) integ_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .smp_ok    (smp_ok),
        .smp_bit   (bit_in),
        .acc3_next (acc3_next)
    );

    sinc3_count #(.LMAX(LMAX), .LOG_W(LOG_W)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .smp_ok   (smp_ok),
        .log2_osr (s_q.log2_osr),
        .fire     (fire)
    );

    sinc3_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LOG_W(LOG_W)) comb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fire       (fire),
        .din        (acc3_next),
        .log2_osr   (s_q.log2_osr),
        .word       (word_out),
        .word_valid (word_valid),
        .settled    (settled)
    );

    // R6: a ratio change is never followed by a word in the next cycle
    assert_change_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !word_valid);

    // R4: the held ratio always lies in the supported range
    assert_ratio_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.log2_osr >= LOG_W'(LMIN)) && (s_q.log2_osr <= LOG_W'(LMAX)));

endmodule

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;
    localparam int LMIN = 4;
    localparam int LMAX = 8;
    localparam int ACC  = 2 + 3 * LMAX;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_valid = 1'b0;
    logic [2:0]  osr_code = 3'd0;
    logic [15:0] word_out;
    logic        word_valid;
    logic        settled;

    always #2 clk = ~clk;

    sinc3_decim dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .osr_code(osr_code), .word_out(word_out), .word_valid(word_valid),
        .settled(settled)
    );

    int total = 0;
    int bad = 0;
    longint a1, a2, a3, d1, d2, d3, last_word;
    int cnt, nwords, ml2, obs_words;
    bit exp_valid, exp_settled, prev_settled;
    longint exp_word;
    string wtag;

    function automatic longint wrap(input longint v);
        return v & ((64'sd1 <<< ACC) - 1);
    endfunction

    function automatic longint sgn(input longint v);
        longint w;
        w = wrap(v);
        if (w >= (64'sd1 <<< (ACC - 1))) w = w - (64'sd1 <<< ACC);
        return w;
    endfunction

    function automatic longint scale(input longint v, input int l2);
        int sh;
        longint r;
        sh = 3 * l2 - 15;
        if (sh >= 0) r = v >>> sh;
        else         r = v <<< (-sh);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int eff(input int code);
        return (LMIN + code > LMAX) ? LMAX : LMIN + code;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        a1 = 0; a2 = 0; a3 = 0; d1 = 0; d2 = 0; d3 = 0;
        cnt = 0; nwords = 0; exp_settled = 0;
    endtask

    task automatic step(input int code, input bit b, input bit v);
        bit fl;
        longint n1, n2, n3, c1, c2, c3, act;
        @(negedge clk);
        osr_code = 3'(code); bit_in = b; bit_valid = v;
        @(posedge clk);
        #1;
        exp_valid = 0;
        fl = (eff(code) != ml2);
        if (fl) begin
            ml2 = eff(code);
            model_clear();
            obs_words = 0;
        end else if (v) begin
            n1 = wrap(a1 + (b ? 1 : -1));
            n2 = wrap(a2 + a1);
            n3 = wrap(a3 + a2);
            a1 = n1; a2 = n2; a3 = n3;
            cnt++;
            if (cnt == (1 << ml2)) begin
                cnt = 0;
                c1 = wrap(n3 - d1); c2 = wrap(c1 - d2); c3 = wrap(c2 - d3);
                d1 = n3; d2 = c1; d3 = c2;
                exp_word = scale(sgn(c3), ml2);
                exp_valid = 1;
                nwords++;
                if (nwords >= 3) exp_settled = 1;
            end
        end
        act = longint'($signed(word_out));
        if (fl) begin
            chk(!word_valid && !settled, "R6 flush", {word_valid, settled}, 0);
        end else begin
            chk(word_valid == exp_valid, "R3 strobe", word_valid, exp_valid);
            if (exp_valid) chk(act == exp_word, wtag, act, exp_word);
            chk(settled == exp_settled, "R7 settled", settled, exp_settled);
        end
        if (word_valid) begin
            obs_words++;
            last_word = act;
        end
        if (settled && !prev_settled) chk(obs_words == 3, "R7 third word", obs_words, 3);
        prev_settled = settled;
    endtask

    task automatic run_rand(input int code, input int n, input int pct1, input int pctv);
        for (int i = 0; i < n; i++) begin
            step(code, ($urandom % 100) < pct1, ($urandom % 100) < pctv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R3 watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        ml2 = LMIN; model_clear(); obs_words = 0; prev_settled = 0; last_word = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(word_out == 16'd0 && !word_valid && !settled, "R1 in reset", {word_out, word_valid, settled}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(word_out == 16'd0 && !word_valid && !settled, "R1 after reset", {word_out, word_valid, settled}, 0);

        // R2: random stream at OSR 16 (left-shift path of R5)
        wtag = "R2 word osr16";
        run_rand(0, 200, 50, 80);

        // R8: constant one at OSR 64
        wtag = "R8 dc high";
        for (int i = 0; i < 64 * 5; i++) step(2, 1'b1, 1'b1);
        chk(last_word == 32767, "R8 positive clamp", last_word, 32767);

        // R8: constant zero at OSR 256
        wtag = "R8 dc low";
        for (int i = 0; i < 256 * 4; i++) step(4, 1'b0, 1'b1);
        chk(last_word == -32768, "R8 negative clamp", last_word, -32768);

        // R4: codes 5 and 7 alias code 4, no flush
        wtag = "R4 alias";
        step(7, 1'b0, 1'b1);
        chk(settled == 1'b1, "R4 code 7 keeps settled", settled, 1);
        for (int i = 0; i < 300; i++) step(5, 1'b0, 1'b1);
        chk(settled == 1'b1, "R4 code 5 keeps settled", settled, 1);

        // R8: alternating stream at OSR 128
        wtag = "R8 alternating";
        for (int i = 0; i < 128 * 5; i++) step(3, 1'(i % 2), 1'b1);
        chk(last_word == 0, "R8 alternating zero", last_word, 0);

        // R3: sparse strobes at OSR 32
        wtag = "R3 sparse";
        run_rand(1, 600, 60, 30);

        // R6: ratio change in the middle of a frame
        wtag = "R6 after change";
        run_rand(2, 40, 50, 100);
        step(0, 1'b1, 1'b1);
        chk(!settled, "R6 settled cleared", settled, 0);
        run_rand(0, 120, 40, 100);

        // R5: biased random at each ratio
        wtag = "R5 scaled";
        for (int c = 0; c < 5; c++) run_rand(c, (1 << (LMIN + c)) * 4 + 20, 70, 90);
        run_rand(4, 1200, 15, 95);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule